// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block sequences the control flow of one warp of lockstep lanes when those lanes disagree on a conditional branch. It holds the warp's current program counter, the mask of lanes that are active, and the reconvergence point of the path that is running. Below that it keeps a stack of deferred work. When a branch splits the active lanes, the lanes that take the branch run first. Two entries are pushed: a merge entry that restores the full mask at the reconvergence point, and a deferred entry for the fall-through lanes. Each path runs until its program counter equals its reconvergence point. The top entry is then popped, which either starts the deferred path at its own program counter or merges the lanes back together.

Instructions reach the block as events, each a valid/ready transfer that shares one ready signal. A sequential-step event carries the next program counter chosen by fetch and, optionally, a reconvergence point to latch for the next branch. A branch event carries a per-lane taken vector, the taken target and the fall-through address. The ready signal drops in any cycle where the running path sits at its reconvergence point while the stack holds entries. In that cycle the block pops one entry and ignores any offered event; the producer must hold its event until ready returns. If both valids are high in the same cycle, the branch is accepted and the step is dropped. Status pins (empty, overflow) are plain levels.

Top module: `simt_reconv_stack`

## Requirements
- R1: Reset leaves the program counter at RESET_PC and all lanes active, sets the empty flag to 1 and clears the overflow flag.
- R2: An accepted step event moves the program counter to the supplied next PC on the following clock edge and leaves the mask unchanged. When its set flag is 1, the reconvergence point it carries is latched for later branches.
- R3: A branch where every active lane takes, or no active lane takes, pushes nothing. It moves the program counter to the target or to the fall-through address respectively and leaves the mask unchanged.
- R4: A branch that splits the active lanes always continues at the taken target with only the taken lanes active, whatever the lane indices or lane counts on each side. The latched reconvergence point becomes the running path's reconvergence point.
- R5: While the running path's program counter equals its reconvergence point and the stack is non-empty, ev_ready is 0 and an offered event has no effect.
- R6: Popping a deferred entry resumes at the fall-through address of the split, with only the fall-through lanes active.
- R7: When the deferred path reaches the reconvergence point, the merge entry is popped and the mask returns to the union of both paths. At stack depth zero the mask is all ones.
- R8: A split branch when fewer than two stack slots are free pushes nothing, sets the overflow flag, and continues at the fall-through address with the mask unchanged. Existing entries stay intact, and the overflow flag stays set until reset.
- R9: empty_o is 1 exactly when the stack holds no entries.
- R10: Taken bits of inactive lanes are disregarded when a branch is classified.
- R11: Nested splits unwind last-in-first-out. In a chain of else-if tests, each compiled as a branch taken toward the next test, the last then-clause runs first and the first then-clause runs last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch event offered |
| br_taken | input | LANES | Per-lane branch outcome, 1 = taken |
| br_target | input | PC_W | Taken target address |
| br_fall | input | PC_W | Fall-through address |
| st_valid | input | 1 | Sequential-step event offered |
| st_next_pc | input | PC_W | Next PC from fetch |
| st_set_rpc | input | 1 | Step also latches a reconvergence point |
| st_rpc | input | PC_W | Reconvergence point to latch |
| ev_ready | output | 1 | Events accepted this cycle |
| pc_o | output | PC_W | Program counter of the running path |
| mask_o | output | LANES | Active lane mask |
| empty_o | output | 1 | Stack holds no entries |
| overflow_o | output | 1 | Sticky stack overflow flag |

## Verification
The bench builds the block with 32 lanes, a 16-bit program counter and a stack depth of 4. At that depth two nested splits fill the stack and a third split reaches the overflow path, so the overflow behaviour and the unwinding of a full stack after overflow are both exercised in a short run. The full lane width keeps the lane-count independence cases realistic: 31 lanes against 1 lane, 1 lane against 31, and two halves. It also covers the back-to-back pops that occur when nested paths share one reconvergence point.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;
  typedef enum logic [1:0] {
    BR_ALL_FALL  = 2'd0,
    BR_ALL_TAKEN = 2'd1,
    BR_SPLIT     = 2'd2
  } br_kind_e;
endpackage

// File: rtl/simt_branch_classify.sv
module simt_branch_classify
  import simt_reconv_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] active,
  input  logic [LANES-1:0] taken,
  output logic [LANES-1:0] t_mask,
  output logic [LANES-1:0] f_mask,
  output br_kind_e         kind
);
  // Only active lanes vote (R10)
  always_comb begin
    t_mask = taken & active;
    f_mask = active & ~taken;
    if (t_mask == '0)      kind = BR_ALL_FALL;
    else if (f_mask == '0) kind = BR_ALL_TAKEN;
    else                   kind = BR_SPLIT;
  end

  // R4: a split hands every active lane to exactly one side
  always_comb begin
    if (kind == BR_SPLIT) begin
      assert ((t_mask & f_mask) == '0 && (t_mask | f_mask) == active)
        else $error("p_split_partition_r4");
    end
  end
endmodule

// File: rtl/simt_path_stack.sv
module simt_path_stack #(
  parameter int ENT_W = 80,
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push2,
  input  logic [ENT_W-1:0] lo_ent,
  input  logic [ENT_W-1:0] hi_ent,
  input  logic             pop,
  output logic [ENT_W-1:0] top_ent,
  output logic             room2,
  output logic             empty
);
  logic [CNT_W-1:0] cnt_q;
  logic [ENT_W-1:0] slot_q [DEPTH];
  logic [IDX_W-1:0] top_idx;

  assign room2   = cnt_q <= CNT_W'(DEPTH - 2);
  assign empty   = cnt_q == '0;
  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign top_ent = slot_q[top_idx];

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (push2) cnt_q <= cnt_q + CNT_W'(2);
    else if (pop)   cnt_q <= cnt_q - CNT_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push2 && CNT_W'(i) == cnt_q)
        slot_q[i] <= lo_ent;
      else if (push2 && CNT_W'(i) == cnt_q + CNT_W'(1))
        slot_q[i] <= hi_ent;
    end
  end

  // R8: a push never lands past the last slot
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    push2 |-> cnt_q <= CNT_W'(DEPTH - 2));
  // R9: pop never happens on an empty stack
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R8: a cycle without push or pop keeps the occupancy
  p_hold_depth_r8: assert property (@(posedge clk) disable iff (rst)
    (!push2 && !pop) |=> $stable(cnt_q));
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_reconv_pkg::*;
#(
  parameter int          LANES    = 32,
  parameter int          PC_W     = 32,
  parameter int          DEPTH    = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fall,
  input  logic             st_valid,
  input  logic [PC_W-1:0]  st_next_pc,
  input  logic             st_set_rpc,
  input  logic [PC_W-1:0]  st_rpc,
  output logic             ev_ready,
  output logic [PC_W-1:0]  pc_o,
  output logic [LANES-1:0] mask_o,
  output logic             empty_o,
  output logic             overflow_o
);
  localparam int ENT_W = 2 * PC_W + LANES;

  logic [PC_W-1:0]  pc_q, rpc_q, pend_q;
  logic [LANES-1:0] mask_q;
  logic             ovf_q;

  logic [LANES-1:0] t_mask, f_mask;
  br_kind_e         kind;
  logic [ENT_W-1:0] lo_ent, hi_ent, top_ent;
  logic             room2, stk_empty, at_rpc, push2, br_acc, st_acc;
  logic [PC_W-1:0]  top_pc, top_rpc;
  logic [LANES-1:0] top_mask;

  simt_branch_classify #(.LANES(LANES)) u_cls (
    .active(mask_q), .taken(br_taken),
    .t_mask(t_mask), .f_mask(f_mask), .kind(kind)
  );

  // entry layout: {pc, mask, reconvergence pc}
  assign lo_ent = {pend_q, mask_q, rpc_q};
  assign hi_ent = {br_fall, f_mask, pend_q};
  assign {top_pc, top_mask, top_rpc} = top_ent;

  assign at_rpc   = !stk_empty && (pc_q == rpc_q);
  assign ev_ready = !at_rpc;
  assign br_acc   = br_valid && ev_ready;
  assign st_acc   = st_valid && ev_ready && !br_valid;
  assign push2    = br_acc && (kind == BR_SPLIT) && room2;

  simt_path_stack #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push2(push2), .lo_ent(lo_ent), .hi_ent(hi_ent),
    .pop(at_rpc), .top_ent(top_ent), .room2(room2), .empty(stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_PC;
      mask_q <= '1;
      rpc_q  <= '0;
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else if (at_rpc) begin
      pc_q   <= top_pc;
      mask_q <= top_mask;
      rpc_q  <= top_rpc;
    end else if (br_acc) begin
      unique case (kind)
        BR_ALL_TAKEN: pc_q <= br_target;
        BR_ALL_FALL:  pc_q <= br_fall;
        default: begin
          if (room2) begin
            pc_q   <= br_target;
            mask_q <= t_mask;
            rpc_q  <= pend_q;
          end else begin
            pc_q  <= br_fall;
            ovf_q <= 1'b1;
          end
        end
      endcase
    end else if (st_acc) begin
      pc_q <= st_next_pc;
      if (st_set_rpc) pend_q <= st_rpc;
    end
  end

  assign pc_o       = pc_q;
  assign mask_o     = mask_q;
  assign empty_o    = stk_empty;
  assign overflow_o = ovf_q;

  // R8: overflow flag is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  // R4: an accepted split with room continues at the taken target
  p_taken_first_r4: assert property (@(posedge clk) disable iff (rst)
    push2 |=> pc_q == $past(br_target) && !empty_o);
  // R7: with no deferred work every lane is active
  p_full_mask_when_empty_r7: assert property (@(posedge clk) disable iff (rst)
    empty_o |-> mask_q == '1);
  // R5: an ignored event leaves the latched reconvergence point alone
  p_stall_ignores_r5: assert property (@(posedge clk) disable iff (rst)
    !ev_ready |=> $stable(pend_q));
  // R4: the active mask is never empty
  p_mask_live_r4: assert property (@(posedge clk) disable iff (rst)
    mask_q != '0);
endmodule

// File: tb/tb_simt_reconv_stack.sv
module tb_simt_reconv_stack;
  localparam int LANES = 32;
  localparam int PC_W  = 16;
  localparam int DEPTH = 4;
  localparam logic [15:0] RST_PC = 16'h0100;

  logic clk = 0, rst = 1;
  logic br_valid = 0, st_valid = 0, st_set_rpc = 0;
  logic [31:0] br_taken = 0;
  logic [15:0] br_target = 0, br_fall = 0, st_next_pc = 0, st_rpc = 0;
  logic ev_ready, empty_o, overflow_o;
  logic [15:0] pc_o;
  logic [31:0] mask_o;

  always #5 clk = ~clk;

  simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(RST_PC)) dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target), .br_fall(br_fall), .st_valid(st_valid),
    .st_next_pc(st_next_pc), .st_set_rpc(st_set_rpc), .st_rpc(st_rpc),
    .ev_ready(ev_ready), .pc_o(pc_o), .mask_o(mask_o),
    .empty_o(empty_o), .overflow_o(overflow_o)
  );

  typedef struct { logic [15:0] pc; logic [31:0] mask; logic [15:0] rpc; } ent_t;
  ent_t q[$];
  logic [15:0] m_pc, m_rpc, m_pend;
  logic [31:0] m_mask;
  bit m_ovf;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic mreset();
    q.delete(); m_pc = RST_PC; m_mask = '1; m_rpc = 0; m_pend = 0; m_ovf = 0;
  endtask

  function automatic bit m_ready();
    return !(q.size() > 0 && m_pc == m_rpc);
  endfunction

  task automatic compare(string tag);
    n_tests++;
    if (ev_ready !== m_ready() || pc_o !== m_pc || mask_o !== m_mask ||
        empty_o !== (q.size() == 0) || overflow_o !== m_ovf) begin
      n_fail++;
      $display("FAIL %s: got rdy=%0b pc=%h mask=%h empty=%0b ovf=%0b exp rdy=%0b pc=%h mask=%h empty=%0b ovf=%0b",
               tag, ev_ready, pc_o, mask_o, empty_o, overflow_o,
               m_ready(), m_pc, m_mask, q.size() == 0, m_ovf);
    end
  endtask

  task automatic expect_out(string tag, logic [15:0] pc, logic [31:0] mask, bit emp, bit ovf);
    n_tests++;
    if (pc_o !== pc || mask_o !== mask || empty_o !== emp || overflow_o !== ovf) begin
      n_fail++;
      $display("FAIL %s: got pc=%h mask=%h empty=%0b ovf=%0b exp pc=%h mask=%h empty=%0b ovf=%0b",
               tag, pc_o, mask_o, empty_o, overflow_o, pc, mask, emp, ovf);
    end
  endtask

  task automatic expect_ready(string tag, bit r);
    n_tests++;
    if (ev_ready !== r) begin
      n_fail++;
      $display("FAIL %s: got ready=%0b exp ready=%0b", tag, ev_ready, r);
    end
  endtask

  task automatic drive(string tag, bit bv, logic [31:0] tk, logic [15:0] tg, logic [15:0] fl,
                       bit sv, logic [15:0] sp, bit ss, logic [15:0] sr);
    logic [31:0] t, f;
    ent_t e;
    @(negedge clk);
    compare(tag);
    br_valid = bv; br_taken = tk; br_target = tg; br_fall = fl;
    st_valid = sv; st_next_pc = sp; st_set_rpc = ss; st_rpc = sr;
    if (!m_ready()) begin
      e = q.pop_back(); m_pc = e.pc; m_mask = e.mask; m_rpc = e.rpc;
    end else if (bv) begin
      t = tk & m_mask; f = m_mask & ~tk;
      if (t == 0) m_pc = fl;
      else if (f == 0) m_pc = tg;
      else if (q.size() + 2 <= DEPTH) begin
        q.push_back('{pc: m_pend, mask: m_mask, rpc: m_rpc});
        q.push_back('{pc: fl, mask: f, rpc: m_pend});
        m_pc = tg; m_mask = t; m_rpc = m_pend;
      end else begin
        m_ovf = 1; m_pc = fl;
      end
    end else if (sv) begin
      m_pc = sp;
      if (ss) m_pend = sr;
    end
    @(posedge clk); #1;
    br_valid = 0; st_valid = 0; st_set_rpc = 0;
  endtask

  task automatic idle(string tag);          drive(tag, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic step(string tag, logic [15:0] p); drive(tag, 0, 0, 0, 0, 1, p, 0, 0); endtask
  task automatic setrp(string tag, logic [15:0] p, logic [15:0] r); drive(tag, 0, 0, 0, 0, 1, p, 1, r); endtask
  task automatic br(string tag, logic [31:0] tk, logic [15:0] tg, logic [15:0] fl);
    drive(tag, 1, tk, tg, fl, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1; mreset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
  endtask

  initial begin
    do_reset();
    idle("R1 reset");
    expect_out("R1 reset state", RST_PC, 32'hFFFF_FFFF, 1, 0);
    step("R2 step", 16'h0101);
    expect_out("R2 step pc", 16'h0101, 32'hFFFF_FFFF, 1, 0);
    setrp("R2 latch rpc", 16'h0102, 16'h0150);
    br("R3 uniform taken", 32'hFFFF_FFFF, 16'h0110, 16'h0103);
    expect_out("R3 all taken", 16'h0110, 32'hFFFF_FFFF, 1, 0);
    br("R3 uniform fall", 32'h0, 16'h0120, 16'h0111);
    expect_out("R3 none taken", 16'h0111, 32'hFFFF_FFFF, 1, 0);
    br("R4 split halves", 32'h0000_FFFF, 16'h0200, 16'h0300);
    expect_out("R4 taken side first", 16'h0200, 32'h0000_FFFF, 0, 0);
    step("R4 taken path", 16'h0201);
    step("R5 reach rpc", 16'h0150);
    expect_ready("R5 ready low at rpc", 0);
    step("R5 event offered while stalled", 16'h0999);
    expect_out("R6 deferred resumes", 16'h0300, 32'hFFFF_0000, 0, 0);
    br("R10 inactive lanes only", 32'h0000_FFFF, 16'h0400, 16'h0301);
    expect_out("R10 classified as fall", 16'h0301, 32'hFFFF_0000, 0, 0);
    step("R6 deferred reach rpc", 16'h0150);
    idle("R7 merge pop");
    expect_out("R7 union restored", 16'h0150, 32'hFFFF_FFFF, 1, 0);
    setrp("R4 setrp", 16'h0151, 16'h0180);
    br("R4 many taken", 32'hFFFF_FFFE, 16'h0500, 16'h0600);
    expect_out("R4 31 taken first", 16'h0500, 32'hFFFF_FFFE, 0, 0);
    step("R4 reach", 16'h0180);
    idle("R6 pop");
    expect_out("R6 lane0 deferred", 16'h0600, 32'h0000_0001, 0, 0);
    step("R6 reach", 16'h0180);
    idle("R7 pop");
    expect_out("R9 empty again", 16'h0180, 32'hFFFF_FFFF, 1, 0);
    setrp("R4 setrp2", 16'h0181, 16'h0190);
    br("R4 one taken", 32'h0000_0001, 16'h0510, 16'h0610);
    expect_out("R4 single lane taken first", 16'h0510, 32'h0000_0001, 0, 0);
    step("R4 reach2", 16'h0190);
    idle("R6 pop2");
    step("R6 reach2", 16'h0190);
    idle("R7 pop2");
    expect_out("R7 merged2", 16'h0190, 32'hFFFF_FFFF, 1, 0);
    // else-if chain, each test branches toward the next test
    setrp("R11 setrp", 16'h0191, 16'h0700);
    br("R11 test0", 32'hFFFF_FFFE, 16'h0710, 16'h0790);
    br("R11 test1", 32'hFFFF_FFFC, 16'h0720, 16'h0780);
    expect_out("R11 depth full", 16'h0720, 32'hFFFF_FFFC, 0, 0);
    br("R8 test2 overflows", 32'hFFFF_FFF8, 16'h0730, 16'h0770);
    expect_out("R8 overflow fall", 16'h0770, 32'hFFFF_FFFC, 0, 1);
    step("R11 reach", 16'h0700);
    idle("R11 pop");
    expect_out("R11 then1 before then0", 16'h0780, 32'h0000_0002, 0, 1);
    step("R11 reach1", 16'h0700);
    idle("R11 merge inner");
    expect_ready("R11 chained pop pending", 0);
    idle("R11 pop outer");
    expect_out("R11 then0 last", 16'h0790, 32'h0000_0001, 0, 1);
    step("R11 reach0", 16'h0700);
    idle("R7 final merge");
    expect_out("R8 sticky after unwind", 16'h0700, 32'hFFFF_FFFF, 1, 1);
    idle("R8 hold");
    do_reset();
    idle("R1 reset clears ovf");
    expect_out("R1 second reset", RST_PC, 32'hFFFF_FFFF, 1, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule